// File: doc/BRIEF.md
# Watchdog Overflow Reset Controller

This block counts prescaled ticks in an up-counter and turns a counter overflow into one of two events. In interval mode an overflow wraps the counter and raises a one-cycle interrupt pulse. In watchdog mode an overflow latches a sticky status flag, stops the timer, returns the counter and timer control register to their initial values and, if software enabled it, requests a power-on or a manual reset for a fixed number of cycles.

Software reaches three byte-wide registers through a simple read/write port. The registers are the counter, the timer control register and the reset control register. Every write is guarded: it takes effect only when the upper byte of the 16-bit write word carries a key. The overflow flag can be cleared only by a write of 0 that follows a read in which the flag was seen as 1. It survives the reset pulse, so software can find out why the chip restarted.

Top module: `wdt_rstctl`

## Requirements
- R1: After the synchronous reset, the counter (address 0) reads 0x00, the timer control register (address 1) reads 0x00, the reset control register (address 2) reads 0x1F, and the interrupt and both reset outputs are low.
- R2: A write changes a register only when bus_wdata[15:8] equals the key 0x5A. The register data is in bus_wdata[7:0]. A write with any other upper byte has no effect.
- R3: While timer control bit 6 (run) is 1, the counter rises by one in each cycle where tick is high. A keyed write to address 0 loads the counter.
- R4: With timer control bit 7 (mode) at 0 (interval mode), a counter step from 0xFF wraps to 0x00, irq is high for exactly one cycle, the overflow flag is not set, and no reset output is asserted.
- R5: With mode at 1 (watchdog mode), a counter step from 0xFF sets the overflow flag (reset control bit 7) and returns the counter and the timer control register to 0x00.
- R6: If reset control bit 6 (enable) was 1 at a watchdog overflow, the selected reset output goes high in the next cycle and stays high for exactly 128 cycles. If the enable bit was 0, neither reset output goes high. The overflow flag stays set across the pulse.
- R7: Reset control bit 5 selects the reset type: 0 drives rst_por, 1 drives rst_man. The two outputs are never high together.
- R8: A keyed write with bit 7 = 0 clears the overflow flag only if a read of address 2 returned the flag as 1 since the last write to that register. Without such a read the flag stays set. Writing bit 7 = 1 never sets the flag.
- R9: Reset control bits 4..0 always read as 1, whatever value is written to them.
- R10: A read strobe places the addressed register on bus_rdata in the following cycle. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| bus_addr | input | 2 | Register select: 0 counter, 1 timer control, 2 reset control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Key in the upper byte, data in the lower byte |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | One-cycle interval overflow pulse |
| rst_por | output | 1 | Power-on reset request |
| rst_man | output | 1 | Manual reset request |

## Verification
A counter that is wrong by one step changes the cycle in which an overflow fires, so irq or a reset output moves by a cycle, and the per-cycle comparison catches it at that edge. A wrong overflow flag or a wrong clear-arming state stays hidden until the next read of address 2, and that read exposes it one cycle after the strobe. A reset pulse that is off by one in length shows as a mismatch on the first cycle where rst_por or rst_man differs from the model, at most 129 cycles after the overflow.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CNT = 2'd0,
    SEL_TCR = 2'd1,
    SEL_RCR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          clr,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic step;
  assign step   = run && tick;
  assign wrap_o = step && !ld && (cnt_o == MAXV);

  always_ff @(posedge clk) begin
    if (rst)       cnt_o <= '0;
    else if (ld)   cnt_o <= ld_val;
    else if (clr)  cnt_o <= '0;
    else if (step) cnt_o <= cnt_o + 1'b1;
  end

  // R3: a plain step moves the count by exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && !clr) |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R3: no tick, no load, no clear -> count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !ld && !clr) |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_rcr.sv
module wdt_rcr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          set_flag,
  output logic [DW-1:0] q_o,
  output logic          ena_o,
  output logic          typ_o
);
  localparam int RSV = DW - 3;

  logic flag_q, arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      ena_o  <= 1'b0;
      typ_o  <= 1'b0;
    end else begin
      if (rd && flag_q) arm_q <= 1'b1;
      else if (wr)      arm_q <= 1'b0;
      if (wr) begin
        ena_o <= wdata[DW-2];
        typ_o <= wdata[DW-3];
      end
      if (set_flag)                        flag_q <= 1'b1;
      else if (wr && arm_q && !wdata[DW-1]) flag_q <= 1'b0;
    end
  end

  assign q_o = {flag_q, ena_o, typ_o, {RSV{1'b1}}};

  // R8: the flag only falls after an arming read
  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(arm_q));
  // R8: the flag only rises on an overflow
  a_r8_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(set_flag));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sel,
  output logic por_o,
  output logic man_o
);
  localparam int CNTW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(LEN - 1);

  logic            busy_q, typ_q;
  logic [CNTW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      typ_q  <= 1'b0;
      len_q  <= '0;
    end else if (busy_q) begin
      len_q <= len_q + 1'b1;
      if (len_q == LAST) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      typ_q  <= sel;
      len_q  <= '0;
    end
  end

  assign por_o = busy_q && !typ_q;
  assign man_o = busy_q && typ_q;

  // R7: one reset type at a time
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(por_o && man_o));
  // R6: the pulse ends only after the full length
  a_r6_full_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(len_q) == LAST));
  // R7: the reset type holds for the whole pulse
  a_r7_type_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_q && len_q != LAST) |=> (busy_q && $stable(typ_q)));
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl #(
  parameter int          DW        = 8,
  parameter logic [7:0]  WKEY      = 8'h5A,
  parameter int          PULSE_LEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq,
  output logic            rst_por,
  output logic            rst_man
);
  import wdt_pkg::*;

  localparam int RSV = DW - 3;

  logic          key_ok, wr_cnt, wr_tcr, wr_rcr, rd_rcr;
  logic          run_q, mode_q, wrap, wd_ovf;
  logic [DW-1:0] cnt, rcr_q, tcr_v;
  logic          rcr_ena, rcr_typ;

  assign key_ok = bus_wr && (bus_wdata[2*DW-1:DW] == WKEY[DW-1:0]);
  assign wr_cnt = key_ok && (bus_addr == SEL_CNT);
  assign wr_tcr = key_ok && (bus_addr == SEL_TCR);
  assign wr_rcr = key_ok && (bus_addr == SEL_RCR);
  assign rd_rcr = bus_rd && (bus_addr == SEL_RCR);

  wdt_cnt #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick),
    .ld(wr_cnt), .ld_val(bus_wdata[DW-1:0]), .clr(wd_ovf),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  assign wd_ovf = wrap && mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (wd_ovf) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_tcr) begin
      mode_q <= bus_wdata[DW-1];
      run_q  <= bus_wdata[DW-2];
    end
  end

  assign tcr_v = {mode_q, run_q, {(DW-2){1'b0}}};

  wdt_rcr #(.DW(DW)) u_rcr (
    .clk(clk), .rst(rst), .wr(wr_rcr), .wdata(bus_wdata[DW-1:0]),
    .rd(rd_rcr), .set_flag(wd_ovf),
    .q_o(rcr_q), .ena_o(rcr_ena), .typ_o(rcr_typ)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(wd_ovf && rcr_ena), .sel(rcr_typ),
    .por_o(rst_por), .man_o(rst_man)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq <= wrap && !mode_q;
      if (bus_rd) begin
        case (bus_addr)
          SEL_CNT: bus_rdata <= cnt;
          SEL_TCR: bus_rdata <= tcr_v;
          SEL_RCR: bus_rdata <= rcr_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R4: the flag never rises from an interval-mode wrap
  a_r4_no_flag_interval: assert property (@(posedge clk) disable iff (rst)
    $rose(rcr_q[DW-1]) |-> $past(mode_q));
  // R4: the interrupt lasts a single cycle
  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R5: a watchdog overflow stops the timer and zeroes the count
  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    wd_ovf |=> (!run_q && !mode_q && cnt == '0));
  // R6: a reset request starts only from an enabled watchdog overflow
  a_r6_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_por || rst_man) |-> $past(wd_ovf && rcr_ena));
  // R9: reserved bits read back as ones
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    $past(rd_rcr) |-> (bus_rdata[RSV-1:0] == {RSV{1'b1}}));
endmodule

// File: tb/tb_wdt_rstctl.sv
module tb_wdt_rstctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0]  bus_rdata;
  logic        irq, rst_por, rst_man;

  int n_chk = 0, n_bad = 0;
  int c_por = 0, c_man = 0, c_irq = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_rstctl dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_por(rst_por), .rst_man(rst_man)
  );

  // behavioural reference model
  int m_cnt, m_left, m_rdata;
  bit m_run, m_mode, m_flag, m_ena, m_typ, m_arm, m_irq, m_ptyp;

  always @(posedge clk) begin
    bit ok, ovf, nflag, narm;
    int rv;
    if (rst) begin
      m_cnt = 0; m_left = 0; m_rdata = 0; m_run = 0; m_mode = 0; m_flag = 0;
      m_ena = 0; m_typ = 0; m_arm = 0; m_irq = 0; m_ptyp = 0;
    end else begin
      ok  = bus_wr && bus_wdata[15:8] == 8'h5A;
      ovf = m_run && tick && m_cnt == 255 && !(ok && bus_addr == 0);
      if (bus_rd) begin
        rv = 0;
        if (bus_addr == 0) rv = m_cnt;
        if (bus_addr == 1) rv = m_mode * 128 + m_run * 64;
        if (bus_addr == 2) rv = m_flag * 128 + m_ena * 64 + m_typ * 32 + 31;
        m_rdata = rv;
      end
      narm = m_arm;
      if (bus_rd && bus_addr == 2 && m_flag) narm = 1;
      else if (ok && bus_addr == 2) narm = 0;
      nflag = m_flag;
      if (ok && bus_addr == 2 && !bus_wdata[7] && m_arm) nflag = 0;
      if (ovf && m_mode) nflag = 1;
      if (m_left > 0) m_left = m_left - 1;
      else if (ovf && m_mode && m_ena) begin m_left = 128; m_ptyp = m_typ; end
      if (ok && bus_addr == 2) begin m_ena = bus_wdata[6]; m_typ = bus_wdata[5]; end
      m_irq = ovf && !m_mode;
      if (ok && bus_addr == 0) m_cnt = bus_wdata[7:0];
      else if (ovf && m_mode) m_cnt = 0;
      else if (m_run && tick) m_cnt = (m_cnt + 1) % 256;
      if (ovf && m_mode) begin m_run = 0; m_mode = 0; end
      else if (ok && bus_addr == 1) begin m_mode = bus_wdata[7]; m_run = bus_wdata[6]; end
      m_flag = nflag; m_arm = narm;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R10 rdata", bus_rdata, m_rdata);
      check("R4 irq", irq, m_irq);
      check("R7 rst_por", rst_por, (m_left > 0 && !m_ptyp) ? 1 : 0);
      check("R6 rst_man", rst_man, (m_left > 0 && m_ptyp) ? 1 : 0);
      if (rst_por) c_por++;
      if (rst_man) c_man++;
      if (irq) c_irq++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic zero_counts();
    c_por = 0; c_man = 0; c_irq = 0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    rd(2'd0, v); check("R1 cnt", v, 8'h00);
    rd(2'd1, v); check("R1 tcr", v, 8'h00);
    rd(2'd2, v); check("R1 rcr", v, 8'h1F);
    rd(2'd3, v); check("R10 unused addr", v, 8'h00);
    // R2 key guard
    wr(2'd0, 16'h0033); rd(2'd0, v); check("R2 bad key", v, 8'h00);
    wr(2'd2, 16'hA560); rd(2'd2, v); check("R2 bad key rcr", v, 8'h1F);
    wr(2'd0, 16'h5A33); rd(2'd0, v); check("R2 good key", v, 8'h33);
    // R9 reserved bits
    wr(2'd2, 16'h5A00); rd(2'd2, v); check("R9 zeros written", v, 8'h1F);
    wr(2'd2, 16'h5A60); rd(2'd2, v); check("R9 enable+type", v, 8'h7F);
    // R3 counting
    wr(2'd0, 16'h5A10); wr(2'd1, 16'h5A40);
    ticks(5);
    rd(2'd0, v); check("R3 count", v, 8'h15);
    @(negedge clk); rd(2'd0, v); check("R3 hold w/o tick", v, 8'h15);
    // R4 interval wrap
    wr(2'd0, 16'h5AFD); zero_counts();
    ticks(5);
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R4 wrapped count", v, 8'h02);
    check("R4 irq pulses", c_irq, 1);
    check("R4 no reset", c_por + c_man, 0);
    rd(2'd2, v); check("R4 no flag", v, 8'h7F);
    wr(2'd1, 16'h5A00);
    // R5/R6/R7 manual reset
    wr(2'd0, 16'h5AFE); wr(2'd1, 16'h5AC0); zero_counts();
    ticks(2);
    repeat (200) @(negedge clk);
    check("R6 manual len", c_man, 128);
    check("R7 no por", c_por, 0);
    rd(2'd0, v); check("R5 cnt cleared", v, 8'h00);
    rd(2'd1, v); check("R5 tcr cleared", v, 8'h00);
    // R8 clear protocol: write without read first
    wr(2'd2, 16'h5A60); rd(2'd2, v); check("R8 no clear w/o read", v, 8'hFF);
    wr(2'd2, 16'h5A60); rd(2'd2, v); check("R8 clear after read", v, 8'h7F);
    wr(2'd2, 16'h5AE0); rd(2'd2, v); check("R8 write 1 no set", v, 8'h7F);
    // R6 disabled reset
    wr(2'd2, 16'h5A00);
    wr(2'd0, 16'h5AFF); wr(2'd1, 16'h5AC0); zero_counts();
    ticks(1);
    repeat (150) @(negedge clk);
    check("R6 disabled", c_por + c_man, 0);
    rd(2'd0, v); check("R5 cnt cleared no rst", v, 8'h00);
    rd(2'd1, v); check("R5 tcr cleared no rst", v, 8'h00);
    rd(2'd2, v); check("R5 flag set", v, 8'h9F);
    // R7 power-on type (the read above armed the clear)
    wr(2'd2, 16'h5A40); rd(2'd2, v); check("R8 clear+R7 select", v, 8'h5F);
    wr(2'd0, 16'h5AFF); wr(2'd1, 16'h5AC0); zero_counts();
    ticks(1);
    repeat (150) @(negedge clk);
    check("R7 por len", c_por, 128);
    check("R7 no manual", c_man, 0);
    rd(2'd2, v); check("R6 flag kept", v, 8'hDF);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule